// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Gating

This block is the transmit half of a serial controller. A host writes one byte at a time into a single holding register. The block turns each byte into a serial character on `txd`. It can run in an asynchronous framing (start bit, data, optional parity, stop bits) or in a synchronous framing (data and optional parity only). Bit timing comes from `txc_tick`, a one-cycle strobe that marks each falling edge of the transmit clock. In asynchronous mode every bit spans a selectable number of those edges. In synchronous mode every bit spans exactly one edge.

Mode settings (framing, character length, parity, stop length, baud factor and sync characters) and command settings (enable, break) reach the block as plain inputs that a separate register stage holds. Transmission is allowed only while the enable command is set and `cts_n` is low. A character that has already been accepted is always completed. A write offered while transmission is not allowed is discarded. In synchronous mode the block never leaves the line idle while it is allowed to send: with no data waiting, it repeats the stored sync character or sync pair.

Top module: `sertx`

## Requirements
- R1: Out of reset, and whenever no character is being shifted, `txd` is high (mark), `tx_empty` is high and the holding register is empty.
- R2: An asynchronous character is sent as one low start bit, then `5 + char_len` data bits LSB first, then the parity bit if enabled, then the stop bits at high level. `stop_sel` 0 gives one stop bit, 1 gives one and a half, and 2 or 3 gives two.
- R3: `txd` changes only in the clock cycle after a cycle with `txc_tick` high. Between strobes it holds its value.
- R4: In asynchronous mode each bit lasts F strobes. F is 1, FACTOR_MID or FACTOR_HI for `baud_sel` values 0, 1 and 2/3. In synchronous mode each bit lasts one strobe whatever `baud_sel` holds.
- R5: `tx_ready` is high exactly when `tx_en` is high, `cts_n` is low and the holding register is empty. A write with `wr_valid` high is taken only while `tx_ready` is high.
- R6: A character accepted before `tx_en` falls or `cts_n` rises is still sent in full. A write offered while disabled is dropped: `txd` stays high, `tx_empty` stays high, and nothing is sent after re-enabling.
- R7: `tx_empty` is low from the cycle after a write is accepted until the last bit of that data character has finished.
- R8: In synchronous mode, while enabled and with no data waiting, the block sends `sync_a` by itself. If `dual_sync` is set it alternates `sync_a` and `sync_b`. `tx_empty` stays high while sync characters are sent.
- R9: While `send_break` is high, `txd` is low regardless of the shifter state.
- R10: The parity bit is the XOR of the active data bits when `parity_odd` is 0 (even), and its inverse when `parity_odd` is 1 (odd).
- R11: With one-and-a-half stop bits, the final stop segment lasts F/2 strobes. At F = 1 it lasts one strobe.
- R12: The first bit of a character appears on the strobe that follows an idle line or the end of the previous character, with no gap strobe between back-to-back characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc_tick | input | 1 | One-cycle strobe per falling edge of the transmit clock |
| sync_mode | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| baud_sel | input | 2 | Asynchronous baud factor select |
| char_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_sel | input | 2 | Stop length: 0 one, 1 one and a half, 2/3 two |
| dual_sync | input | 1 | Alternate two sync characters |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| tx_en | input | 1 | Transmit enable command |
| send_break | input | 1 | Force the line low |
| cts_n | input | 1 | Clear to send, active low |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | No data character left to send |

## Verification
The bench builds the block with FACTOR_MID = 4 and FACTOR_HI = 8. These small values let a full frame at each baud factor, including the half-length final stop segment at factor 4, be checked strobe by strobe in a few hundred cycles. At factor 1 the bench checks plain framing, parity polarity and the gating rules. At factors 4 and 8 it checks bit length and the 1.5-stop timing. In synchronous mode it sets `baud_sel` to a factor other than 1, to show that it is ignored there, and checks the data-then-sync sequence with no gap strobes between characters.

// File: rtl/sertx.sv
module sertx #(
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txc_tick,
  input  logic       sync_mode,
  input  logic [1:0] baud_sel,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic [1:0] stop_sel,
  input  logic       dual_sync,
  input  logic [7:0] sync_a,
  input  logic [7:0] sync_b,
  input  logic       tx_en,
  input  logic       send_break,
  input  logic       cts_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);
  localparam int CW = $clog2(FACTOR_HI + 1);

  logic [7:0]    hold_q;
  logic          hold_full;
  logic [11:0]   sh_q;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, data_q, syn_sel_q, line_q;

  logic          gate, accept, finish, bit_end, load_sync;
  logic [CW-1:0] factor, half, dur;
  logic [3:0]    nlen, flen, pos;
  logic [7:0]    src;
  logic [11:0]   frame;
  logic          par;

  assign gate     = tx_en & ~cts_n;
  assign tx_ready = gate & ~hold_full;
  assign accept   = wr_valid & tx_ready;
  assign txd      = line_q & ~send_break;
  assign tx_empty = ~hold_full & ~data_q;

  assign factor = sync_mode          ? CW'(1) :
                  baud_sel == 2'd0   ? CW'(1) :
                  baud_sel == 2'd1   ? CW'(FACTOR_MID) : CW'(FACTOR_HI);
  assign half   = (factor >> 1) == '0 ? CW'(1) : factor >> 1;
  assign dur    = (left_q == 4'd1 && !sync_mode && stop_sel == 2'd1) ? half : factor;
  assign bit_end   = cnt_q == dur - CW'(1);
  assign finish    = ~busy_q | (bit_end & left_q == 4'd1);
  assign load_sync = ~hold_full & sync_mode & gate;
  assign nlen      = 4'd5 + {2'b00, char_len};
  assign src       = hold_full ? hold_q : (syn_sel_q ? sync_b : sync_a);

  always_comb begin
    frame = '1;
    pos   = sync_mode ? 4'd0 : 4'd1;
    if (!sync_mode) frame[0] = 1'b0;
    par = parity_odd;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nlen)) begin
        frame[pos + 4'(i)] = src[i];
        par = par ^ src[i];
      end
    end
    pos = pos + nlen;
    if (parity_en) begin
      frame[pos] = par;
      pos = pos + 4'd1;
    end
    flen = pos + (sync_mode ? 4'd0 : (stop_sel == 2'd0 ? 4'd1 : 4'd2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; hold_full <= 1'b0; sh_q <= '1; left_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; data_q <= 1'b0; syn_sel_q <= 1'b0; line_q <= 1'b1;
    end else begin
      if (accept) begin
        hold_full <= 1'b1;
        hold_q    <= wr_data;
      end
      if (txc_tick) begin
        if (finish) begin
          cnt_q <= '0;
          if (hold_full || load_sync) begin
            busy_q <= 1'b1;
            data_q <= hold_full;
            line_q <= frame[0];
            sh_q   <= {1'b1, frame[11:1]};
            left_q <= flen;
            if (hold_full) begin
              hold_full <= 1'b0;
              syn_sel_q <= 1'b0;
            end else begin
              syn_sel_q <= dual_sync & ~syn_sel_q;
            end
          end else begin
            busy_q <= 1'b0;
            data_q <= 1'b0;
            line_q <= 1'b1;
          end
        end else if (bit_end) begin
          line_q <= sh_q[0];
          sh_q   <= {1'b1, sh_q[11:1]};
          left_q <= left_q - 4'd1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  a_r1_idle_is_mark: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> line_q);
  a_r3_line_waits_for_tick: assert property (@(posedge clk) disable iff (rst)
    !txc_tick |=> $stable(line_q));
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CW'(FACTOR_HI)));
  a_r5_refused_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !tx_ready && !txc_tick) |=> ($stable(hold_q) && $stable(hold_full)));
  a_r6_queued_char_kept: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !txc_tick) |=> hold_full);
  a_r7_accept_clears_empty: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && tx_ready) |=> !tx_empty);
endmodule

// File: tb/sertx_bench.sv
module sertx_bench;
  localparam int FM = 4;
  localparam int FH = 8;

  logic clk = 1'b0, rst = 1'b1, txc_tick = 1'b0;
  logic sync_mode = 1'b0, parity_en = 1'b0, parity_odd = 1'b0, dual_sync = 1'b0;
  logic [1:0] baud_sel = 2'd0, char_len = 2'd3, stop_sel = 2'd0;
  logic [7:0] sync_a = 8'h16, sync_b = 8'h7E, wr_data = 8'h00;
  logic tx_en = 1'b0, send_break = 1'b0, cts_n = 1'b0, wr_valid = 1'b0;
  logic txd, tx_ready, tx_empty;

  int total = 0, bad = 0;
  bit q[$];

  always #5 clk = ~clk;

  sertx #(.FACTOR_MID(FM), .FACTOR_HI(FH)) u_sertx (
    .clk(clk), .rst(rst), .txc_tick(txc_tick), .sync_mode(sync_mode),
    .baud_sel(baud_sel), .char_len(char_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .stop_sel(stop_sel), .dual_sync(dual_sync),
    .sync_a(sync_a), .sync_b(sync_b), .tx_en(tx_en), .send_break(send_break),
    .cts_n(cts_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk) txc_tick = 1'b1;
    @(negedge clk) txc_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic push(input bit v, input int n);
    repeat (n) q.push_back(v);
  endtask

  task automatic play(input string tag);
    foreach (q[i]) begin
      tick;
      chk(txd === q[i], tag, txd, q[i]);
    end
    q.delete();
  endtask

  task automatic build_char(input logic [7:0] d, input int n, input bit sync, input int f);
    bit p;
    p = parity_odd;
    if (!sync) push(1'b0, f);
    for (int i = 0; i < n; i++) begin
      push(d[i], f);
      p ^= d[i];
    end
    if (parity_en) push(p, f);
    if (!sync) begin
      push(1'b1, f);
      if (stop_sel == 2'd1) push(1'b1, (f / 2 < 1) ? 1 : f / 2);
      else if (stop_sel != 2'd0) push(1'b1, f);
    end
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(tx_empty === 1'b1, "R1 reset empty", tx_empty, 1);
    chk(tx_ready === 1'b0, "R5 ready without enable", tx_ready, 0);
    @(negedge clk) tx_en = 1'b1;
    #1 chk(tx_ready === 1'b1, "R5 ready when enabled", tx_ready, 1);
  endtask

  task automatic t_basic_8n1;
    write(8'hA5);
    chk(tx_ready === 1'b0, "R5 ready drops when full", tx_ready, 0);
    chk(tx_empty === 1'b0, "R7 empty low after write", tx_empty, 0);
    tick;
    chk(txd === 1'b0, "R12 start bit on first tick", txd, 0);
    repeat (10) @(negedge clk);
    chk(txd === 1'b0, "R3 no change without tick", txd, 0);
    chk(tx_empty === 1'b0, "R7 empty low while shifting", tx_empty, 0);
    build_char(8'hA5, 8, 1'b0, 1);
    void'(q.pop_front());
    push(1'b1, 1);
    play("R2 8N1 frame");
    chk(tx_empty === 1'b1, "R7 empty after frame", tx_empty, 1);
  endtask

  task automatic t_parity_even_2stop;
    char_len = 2'd0; parity_en = 1'b1; parity_odd = 1'b0; stop_sel = 2'd2;
    write(8'h13);
    build_char(8'h13, 5, 1'b0, 1);
    push(1'b1, 1);
    play("R10 5E2 frame");
  endtask

  task automatic t_odd_onehalf_f4;
    char_len = 2'd2; parity_en = 1'b1; parity_odd = 1'b1; stop_sel = 2'd1; baud_sel = 2'd1;
    write(8'h55);
    build_char(8'h55, 7, 1'b0, FM);
    push(1'b1, 1);
    play("R11 7O1.5 at factor mid");
  endtask

  task automatic t_f8;
    char_len = 2'd1; parity_en = 1'b0; stop_sel = 2'd0; baud_sel = 2'd2;
    write(8'h2A);
    build_char(8'h2A, 6, 1'b0, FH);
    push(1'b1, 1);
    play("R4 6N1 at factor hi");
    char_len = 2'd3; baud_sel = 2'd0;
  endtask

  task automatic t_drop_when_disabled;
    @(negedge clk) cts_n = 1'b1;
    #1 chk(tx_ready === 1'b0, "R5 ready low with cts high", tx_ready, 0);
    write(8'h00);
    push(1'b1, 12);
    play("R6 dropped write stays mark");
    chk(tx_empty === 1'b1, "R6 empty stays high", tx_empty, 1);
    @(negedge clk) cts_n = 1'b0;
    #1 chk(tx_ready === 1'b1, "R6 holding still empty", tx_ready, 1);
    push(1'b1, 3);
    play("R6 nothing sent after re-enable");
  endtask

  task automatic t_queued_then_disable;
    write(8'h0F);
    @(negedge clk) cts_n = 1'b1;
    build_char(8'h0F, 8, 1'b0, 1);
    push(1'b1, 1);
    play("R6 queued char completes");
    chk(tx_empty === 1'b1, "R7 empty after queued char", tx_empty, 1);
    @(negedge clk) begin cts_n = 1'b0; tx_en = 1'b0; end
    write(8'hF0);
    @(negedge clk) tx_en = 1'b1;
    push(1'b1, 4);
    play("R6 command disable drops write");
  endtask

  task automatic t_break;
    @(negedge clk) send_break = 1'b1;
    #1 chk(txd === 1'b0, "R9 break low", txd, 0);
    push(1'b0, 3);
    play("R9 break held over ticks");
    @(negedge clk) send_break = 1'b0;
    #1 chk(txd === 1'b1, "R9 break release", txd, 1);
  endtask

  task automatic t_sync;
    parity_en = 1'b0; stop_sel = 2'd0; baud_sel = 2'd1; dual_sync = 1'b1;
    @(negedge clk) sync_mode = 1'b1;
    write(8'h3C);
    build_char(8'h3C, 8, 1'b1, 1);
    play("R8 sync data char one tick per bit R4");
    chk(tx_empty === 1'b0, "R7 empty low in sync data", tx_empty, 0);
    build_char(sync_a, 8, 1'b1, 1);
    play("R8 first sync char");
    chk(tx_empty === 1'b1, "R8 empty high in sync fill", tx_empty, 1);
    build_char(sync_b, 8, 1'b1, 1);
    play("R8 second sync char");
    @(negedge clk) tx_en = 1'b0;
    tick;
    chk(txd === 1'b1, "R1 mark after sync disable", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic_8n1;
    t_parity_even_2stop;
    t_odd_onehalf_f4;
    t_f8;
    t_drop_when_disabled;
    t_queued_then_disable;
    t_break;
    t_sync;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule